// File: doc/BRIEF.md
# Multiplexed Address/Data Local Bus Slave

This block is the target side of a synchronous 32-bit local bus on which address and data share the same wires. When a bus master starts an access, the slave takes the address from the shared lines at the address strobe. It then checks whether that address falls inside its window. If it does, the slave serves one data beat or a burst of beats against an internal word array, in either direction.

The address appears on the bus only once per access, so the slave keeps its own word pointer and steps it after each completed beat. Before every beat the slave inserts a fixed number of wait states by holding its ready output high. It also respects a master wait input: no beat is transferred in a cycle where the master holds that input low. The access ends on the beat that carries the burst-last flag. In the cycle after that beat, the slave drives ready high for one clock and releases the data lines. In the cycle after that, it releases ready as well. Tri-state pins are modelled as separate input, output and output-enable signals.

Top module: `lbus_mux_slave`

## Requirements
- R1: A rising clock edge at which the address strobe (active low) is sampled low, while no access is in progress and the shared bus holds an address inside [BASE_ADDR, BASE_ADDR + 4*WIN_WORDS), starts an access. The direction select sampled at that same edge fixes the direction: 1 means write, 0 means read.
- R2: After the address phase, and again after every completed beat that is not the last, ready (active low) stays high for exactly WAIT_STATES cycles and is then driven low. Ready is only ever low while its output enable is high.
- R3: During a read access the slave drives the shared bus, and in every cycle with ready low the data it presents is the word stored at the current word pointer.
- R4: During a write, a beat completes at the clock edge where ready is low and the master wait input is high. At that edge the slave stores the bus data into the current word. Only the byte lanes whose enable is low are written: enable bit i controls bits 8i+7..8i. The other lanes keep their old contents.
- R5: Each completed beat that is not the last advances the word pointer by one word. A burst therefore touches consecutive words, starting at the word addressed in the address phase.
- R6: In a cycle where ready is low and the master wait input is low, no data moves. Ready stays low in the next cycle, and the same beat is repeated with the same word.
- R7: When a beat completes with burst-last low, the next cycle has ready driven high and the shared bus released. One cycle later ready is released too, unless a new access has started.
- R8: An address phase whose address lies outside the window causes no response: neither output enable rises, and no stored word changes.
- R9: While reset is high and after it, until an access starts, both output enables are low and ready reads high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, all activity on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| lb_ads_n | input | 1 | Address strobe from the master, active low |
| lb_wr | input | 1 | Direction select: 1 write, 0 read |
| lb_blast_n | input | 1 | Burst-last flag for the current beat, active low |
| lb_wait_n | input | 1 | Master wait request, active low |
| lb_be_n | input | 4 | Byte-lane enables for the current beat, active low |
| lb_ad_in | input | 32 | Shared address/data lines as seen by the slave |
| lb_ad_out | output | 32 | Read data the slave presents on the shared lines |
| lb_ad_oe | output | 1 | Drive enable for the shared lines |
| lb_rdy_n | output | 1 | Ready, active low |
| lb_rdy_oe | output | 1 | Drive enable for ready |

## Verification
The first ready-low cycle is due WAIT_STATES+1 cycles after the address-phase cycle. A beat that is not stalled takes WAIT_STATES+1 cycles, and each master stall adds one cycle. The release of the shared bus and the driving of ready high both fall in the cycle right after the last beat, and ready is released one cycle after that. The bench drives every input on the falling clock edge and samples the outputs there too, so each sample reflects the registers the previous rising edge loaded. A behavioural reference model steps on the same rising edge and predicts the enables, ready and read data for every cycle. Directed checks then confirm the latency, the total cycle count of a stalled burst, the end-of-access release, and data read back after full, partial and rejected writes.

// File: rtl/lbs_pkg.sv
`timescale 1ns/1ps
package lbs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BEAT = 2'd1,
    ST_END  = 2'd2
  } lbs_state_e;
endpackage

// File: rtl/lbs_decode.sv
`timescale 1ns/1ps
// Window decode of the multiplexed address: hit flag and word offset.
module lbs_decode #(
  parameter int BUS_W = 32,
  parameter logic [BUS_W-1:0] BASE_ADDR = 32'h0000_4000,
  parameter int WIN_WORDS = 64,
  parameter int OFF_W = $clog2(WIN_WORDS)
) (
  input  logic [BUS_W-1:0] addr,
  output logic             hit,
  output logic [OFF_W-1:0] off
);
  localparam logic [BUS_W:0] LO = {1'b0, BASE_ADDR};
  localparam logic [BUS_W:0] HI = LO + (BUS_W+1)'(WIN_WORDS * 4);

  logic [BUS_W:0]   addr_x;
  logic [BUS_W-1:0] delta;
  logic             unused_delta;

  assign addr_x = {1'b0, addr};
  assign hit    = (addr_x >= LO) && (addr_x < HI);
  assign delta  = addr - BASE_ADDR;
  assign off    = delta[OFF_W+1:2];
  assign unused_delta = ^{delta[BUS_W-1:OFF_W+2], delta[1:0]};
endmodule

// File: rtl/lbs_mem.sv
`timescale 1ns/1ps
// Word array with byte-lane write and registered read (block RAM style).
module lbs_mem #(
  parameter int WORDS = 64,
  parameter int LANES = 4,
  parameter int OFF_W = $clog2(WORDS)
) (
  input  logic               clk,
  input  logic               we,
  input  logic [LANES-1:0]   wbe,
  input  logic [OFF_W-1:0]   waddr,
  input  logic [8*LANES-1:0] wdata,
  input  logic [OFF_W-1:0]   raddr,
  output logic [8*LANES-1:0] rdata
);
  logic [8*LANES-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) begin
      for (int i = 0; i < LANES; i++) begin
        if (wbe[i]) mem[waddr][8*i +: 8] <= wdata[8*i +: 8];
      end
    end
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/lbs_ctrl.sv
`timescale 1ns/1ps
// Access sequencer: address phase, slave wait states, beats, end of access.
module lbs_ctrl
  import lbs_pkg::*;
#(
  parameter int OFF_W = 6,
  parameter int WAIT_STATES = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ads_n,
  input  logic             wr_sel,
  input  logic             blast_n,
  input  logic             wait_n,
  input  logic             hit,
  input  logic [OFF_W-1:0] hit_off,
  output logic             rdy_n_o,
  output logic             rdy_oe_o,
  output logic             ad_oe_o,
  output logic             we_o,
  output logic [OFF_W-1:0] wr_off_o,
  output logic [OFF_W-1:0] rd_off_o
);
  localparam int CNT_W = $clog2(WAIT_STATES + 2);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WAIT_STATES);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
  localparam logic RDY_AFTER_LOAD = (WAIT_STATES != 0);

  lbs_state_e       st;
  logic [OFF_W-1:0] off_q;
  logic             dir_q;
  logic [CNT_W-1:0] cnt_q;
  logic             rdy_n_q, rdy_oe_q, ad_oe_q;
  logic             accept, beat_done, finish;

  assign accept    = (st != ST_BEAT) && !ads_n && hit;
  assign beat_done = (st == ST_BEAT) && !rdy_n_q && wait_n;
  assign finish    = beat_done && !blast_n;

  assign we_o     = beat_done && dir_q;
  assign wr_off_o = off_q;

  always_comb begin
    if (accept)         rd_off_o = hit_off;
    else if (beat_done) rd_off_o = off_q + OFF_W'(1);
    else                rd_off_o = off_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      off_q    <= '0;
      dir_q    <= 1'b0;
      cnt_q    <= '0;
      rdy_n_q  <= 1'b1;
      rdy_oe_q <= 1'b0;
      ad_oe_q  <= 1'b0;
    end else if (accept) begin
      st       <= ST_BEAT;
      off_q    <= hit_off;
      dir_q    <= wr_sel;
      cnt_q    <= CNT_LOAD;
      rdy_n_q  <= RDY_AFTER_LOAD;
      rdy_oe_q <= 1'b1;
      ad_oe_q  <= !wr_sel;
    end else begin
      case (st)
        ST_BEAT: begin
          if (finish) begin
            st      <= ST_END;
            rdy_n_q <= 1'b1;
            ad_oe_q <= 1'b0;
          end else if (beat_done) begin
            off_q   <= off_q + OFF_W'(1);
            cnt_q   <= CNT_LOAD;
            rdy_n_q <= RDY_AFTER_LOAD;
          end else if (rdy_n_q) begin
            cnt_q <= cnt_q - CNT_ONE;
            if (cnt_q == CNT_ONE) rdy_n_q <= 1'b0;
          end
        end
        ST_END: begin
          st       <= ST_IDLE;
          rdy_oe_q <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  assign rdy_n_o  = rdy_n_q;
  assign rdy_oe_o = rdy_oe_q;
  assign ad_oe_o  = ad_oe_q;
endmodule

// File: rtl/lbus_mux_slave.sv
`timescale 1ns/1ps
// Slave on a synchronous multiplexed address/data local bus.
module lbus_mux_slave #(
  parameter int BUS_W = 32,
  parameter logic [BUS_W-1:0] BASE_ADDR = 32'h0000_4000,
  parameter int WIN_WORDS = 64,
  parameter int WAIT_STATES = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lb_ads_n,
  input  logic             lb_wr,
  input  logic             lb_blast_n,
  input  logic             lb_wait_n,
  input  logic [3:0]       lb_be_n,
  input  logic [BUS_W-1:0] lb_ad_in,
  output logic [BUS_W-1:0] lb_ad_out,
  output logic             lb_ad_oe,
  output logic             lb_rdy_n,
  output logic             lb_rdy_oe
);
  localparam int LANES = BUS_W / 8;
  localparam int OFF_W = $clog2(WIN_WORDS);

  logic             hit, we;
  logic [OFF_W-1:0] hit_off, wr_off, rd_off;

  lbs_decode #(
    .BUS_W(BUS_W), .BASE_ADDR(BASE_ADDR), .WIN_WORDS(WIN_WORDS), .OFF_W(OFF_W)
  ) decode_i (
    .addr(lb_ad_in), .hit(hit), .off(hit_off)
  );

  lbs_ctrl #(
    .OFF_W(OFF_W), .WAIT_STATES(WAIT_STATES)
  ) ctrl_i (
    .clk(clk), .rst(rst),
    .ads_n(lb_ads_n), .wr_sel(lb_wr), .blast_n(lb_blast_n), .wait_n(lb_wait_n),
    .hit(hit), .hit_off(hit_off),
    .rdy_n_o(lb_rdy_n), .rdy_oe_o(lb_rdy_oe), .ad_oe_o(lb_ad_oe),
    .we_o(we), .wr_off_o(wr_off), .rd_off_o(rd_off)
  );

  lbs_mem #(
    .WORDS(WIN_WORDS), .LANES(LANES), .OFF_W(OFF_W)
  ) mem_i (
    .clk(clk), .we(we), .wbe(~lb_be_n[LANES-1:0]), .waddr(wr_off),
    .wdata(lb_ad_in), .raddr(rd_off), .rdata(lb_ad_out)
  );
endmodule

// File: rtl/lbus_mux_slave_chk.sv
`timescale 1ns/1ps
// Protocol checker bound to the slave's ports.
module lbus_mux_slave_chk #(
  parameter int BUS_W = 32,
  parameter logic [BUS_W-1:0] BASE_ADDR = 32'h0000_4000,
  parameter int WIN_WORDS = 64,
  parameter int WAIT_STATES = 1
) (
  input logic             clk,
  input logic             rst,
  input logic             lb_ads_n,
  input logic             lb_wr,
  input logic             lb_blast_n,
  input logic             lb_wait_n,
  input logic [BUS_W-1:0] lb_ad_in,
  input logic             lb_ad_oe,
  input logic             lb_rdy_n,
  input logic             lb_rdy_oe
);
  localparam logic [BUS_W:0] LO = {1'b0, BASE_ADDR};
  localparam logic [BUS_W:0] HI = LO + (BUS_W+1)'(WIN_WORDS * 4);

  logic in_win;
  int unsigned hi_run;

  assign in_win = ({1'b0, lb_ad_in} >= LO) && ({1'b0, lb_ad_in} < HI);

  always_ff @(posedge clk) begin
    if (rst || !(lb_rdy_oe && lb_rdy_n)) hi_run <= 0;
    else if (hi_run < 32'hFFFF) hi_run <= hi_run + 1;
  end

  assert_start_R1: assert property (@(posedge clk) disable iff (rst)
    (!lb_rdy_oe && !lb_ads_n && in_win) |=> (lb_rdy_oe && (lb_ad_oe == !$past(lb_wr))));

  assert_ready_enabled_R2: assert property (@(posedge clk) disable iff (rst)
    !lb_rdy_n |-> lb_rdy_oe);

  assert_wait_bound_R2: assert property (@(posedge clk) disable iff (rst)
    hi_run <= WAIT_STATES + 1);

  assert_read_drive_R3: assert property (@(posedge clk) disable iff (rst)
    lb_ad_oe |-> lb_rdy_oe);

  assert_wait_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (lb_rdy_oe && !lb_rdy_n && !lb_wait_n) |=> (!lb_rdy_n && $stable(lb_ad_oe)));

  assert_last_end_R7: assert property (@(posedge clk) disable iff (rst)
    (lb_rdy_oe && !lb_rdy_n && lb_wait_n && !lb_blast_n) |=> (lb_rdy_oe && lb_rdy_n && !lb_ad_oe));

  assert_miss_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (!lb_rdy_oe && !lb_ads_n && !in_win) |=> !lb_rdy_oe);
endmodule

bind lbus_mux_slave lbus_mux_slave_chk #(
  .BUS_W(BUS_W), .BASE_ADDR(BASE_ADDR), .WIN_WORDS(WIN_WORDS), .WAIT_STATES(WAIT_STATES)
) chk_i (
  .clk(clk), .rst(rst), .lb_ads_n(lb_ads_n), .lb_wr(lb_wr), .lb_blast_n(lb_blast_n),
  .lb_wait_n(lb_wait_n), .lb_ad_in(lb_ad_in), .lb_ad_oe(lb_ad_oe),
  .lb_rdy_n(lb_rdy_n), .lb_rdy_oe(lb_rdy_oe)
);

// File: tb/lbus_mux_slave_tb_top.sv
`timescale 1ns/1ps
module lbus_mux_slave_tb_top;
  localparam logic [31:0] BASE = 32'h0000_4000;
  localparam int WIN = 64;
  localparam int NW  = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lb_ads_n = 1'b1, lb_wr = 1'b0, lb_blast_n = 1'b1, lb_wait_n = 1'b1;
  logic [3:0]  lb_be_n = 4'hF;
  logic [31:0] lb_ad_in = '0;
  logic [31:0] lb_ad_out;
  logic        lb_ad_oe, lb_rdy_n, lb_rdy_oe;

  int checks = 0;
  int errors = 0;
  bit done_flag = 1'b0;

  always #4 clk = ~clk;

  lbus_mux_slave #(.BASE_ADDR(BASE), .WIN_WORDS(WIN), .WAIT_STATES(NW)) dut_i (
    .clk(clk), .rst(rst), .lb_ads_n(lb_ads_n), .lb_wr(lb_wr), .lb_blast_n(lb_blast_n),
    .lb_wait_n(lb_wait_n), .lb_be_n(lb_be_n), .lb_ad_in(lb_ad_in), .lb_ad_out(lb_ad_out),
    .lb_ad_oe(lb_ad_oe), .lb_rdy_n(lb_rdy_n), .lb_rdy_oe(lb_rdy_oe)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit in_window(input logic [31:0] a);
    return (a >= BASE) && (a < BASE + WIN * 4);
  endfunction

  // Behavioural reference model, stepped on the rising edge.
  logic [31:0] ref_mem [WIN];
  bit m_active = 0, m_end = 0, m_dir = 0, m_rdy_low = 0;
  int m_addr = 0, m_cnt = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_active = 0; m_end = 0; m_rdy_low = 0; m_cnt = 0;
    end else begin
      bit acc, bd;
      acc = !m_active && !lb_ads_n && in_window(lb_ad_in);
      bd  = m_active && m_rdy_low && lb_wait_n;
      if (bd && m_dir)
        for (int i = 0; i < 4; i++)
          if (!lb_be_n[i]) ref_mem[m_addr][8*i +: 8] = lb_ad_in[8*i +: 8];
      if (acc) begin
        m_active = 1; m_end = 0; m_dir = lb_wr;
        m_addr = int'((lb_ad_in - BASE) >> 2);
        m_cnt = NW; m_rdy_low = (NW == 0);
      end else if (m_active) begin
        if (bd) begin
          if (!lb_blast_n) begin
            m_active = 0; m_end = 1; m_rdy_low = 0;
          end else begin
            m_addr = (m_addr + 1) % WIN; m_cnt = NW; m_rdy_low = (NW == 0);
          end
        end else if (!m_rdy_low) begin
          m_cnt--;
          if (m_cnt == 0) m_rdy_low = 1;
        end
      end else begin
        m_end = 0;
      end
    end
  end

  // Per-cycle comparison against the model, away from the active edge.
  always @(negedge clk) begin
    if (!rst && !done_flag) begin
      chk(lb_rdy_oe == (m_active || m_end), "R2 ready enable", {31'b0, lb_rdy_oe}, {31'b0, m_active || m_end});
      chk(lb_rdy_n == !(m_active && m_rdy_low), "R2 ready level", {31'b0, lb_rdy_n}, {31'b0, !(m_active && m_rdy_low)});
      chk(lb_ad_oe == (m_active && !m_dir), "R3 bus enable", {31'b0, lb_ad_oe}, {31'b0, m_active && !m_dir});
      if (m_active && !m_dir && m_rdy_low)
        chk(lb_ad_out == ref_mem[m_addr], "R3 read data", lb_ad_out, ref_mem[m_addr]);
    end
  end

  logic [31:0] wd [4];
  logic [31:0] rd [4];

  task automatic access(input logic [31:0] a, input bit wr, input int n, input logic [3:0] be_n,
                        input int wait_beat, output int cyc, output int lat);
    int beat = 0;
    bit waited = 0;
    cyc = 0; lat = 0;
    @(negedge clk);
    lb_ads_n = 0; lb_ad_in = a; lb_wr = wr; lb_blast_n = 1; lb_wait_n = 1; lb_be_n = be_n;
    @(negedge clk);
    lb_ads_n = 1;
    while (beat < n && cyc < 200) begin
      lb_ad_in = wr ? wd[beat] : 32'h0;
      lb_blast_n = (beat == n - 1) ? 1'b0 : 1'b1;
      lb_wait_n = 1;
      if (beat == 0 && lb_rdy_n) lat++;
      if (!lb_rdy_n) begin
        if (wait_beat == beat && !waited) begin
          lb_wait_n = 0; waited = 1;
        end else begin
          if (!wr) rd[beat] = lb_ad_out;
          beat++;
        end
      end
      cyc++;
      @(negedge clk);
    end
    lb_blast_n = 1; lb_wait_n = 1; lb_ad_in = 0; lb_be_n = 4'hF;
    chk(beat == n, "R2 access completed", beat, n);
    // R7: cycle after the last beat.
    chk(lb_rdy_oe && lb_rdy_n && !lb_ad_oe, "R7 end cycle", {29'b0, lb_rdy_oe, lb_rdy_n, lb_ad_oe}, 32'h6);
    @(negedge clk);
    chk(!lb_rdy_oe, "R7 ready released", {31'b0, lb_rdy_oe}, 32'h0);
  endtask

  task automatic ignored_write(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    lb_ads_n = 0; lb_ad_in = a; lb_wr = 1; lb_be_n = 4'h0;
    @(negedge clk);
    lb_ads_n = 1; lb_ad_in = d; lb_blast_n = 0;
    for (int k = 0; k < 5; k++) begin
      chk(!lb_rdy_oe && !lb_ad_oe, "R8 no response", {30'b0, lb_rdy_oe, lb_ad_oe}, 32'h0);
      @(negedge clk);
    end
    lb_blast_n = 1; lb_be_n = 4'hF; lb_ad_in = 0;
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int cyc, lat;
    repeat (4) @(negedge clk);
    chk(!lb_rdy_oe && !lb_ad_oe && lb_rdy_n, "R9 reset state", {29'b0, lb_rdy_oe, lb_ad_oe, lb_rdy_n}, 32'h1);
    rst = 0;
    @(negedge clk);
    chk(!lb_rdy_oe && !lb_ad_oe && lb_rdy_n, "R9 idle after reset", {29'b0, lb_rdy_oe, lb_ad_oe, lb_rdy_n}, 32'h1);

    // R1/R4: single full-word write, R2 latency.
    wd[0] = 32'h1122_3344;
    access(BASE, 1, 1, 4'h0, -1, cyc, lat);
    chk(lat == NW, "R2 first ready latency", lat, NW);
    chk(cyc == NW + 1, "R1 single beat cycles", cyc, NW + 1);

    // R3: single read.
    access(BASE, 0, 1, 4'h0, -1, cyc, lat);
    chk(rd[0] == 32'h1122_3344, "R3 single read", rd[0], 32'h1122_3344);

    // R4: partial write, lanes 0 and 2 enabled.
    wd[0] = 32'hAABB_CCDD;
    access(BASE, 1, 1, 4'b1010, -1, cyc, lat);
    access(BASE, 0, 1, 4'h0, -1, cyc, lat);
    chk(rd[0] == 32'h11BB_33DD, "R4 byte-lane write", rd[0], 32'h11BB_33DD);

    // R5: burst write and burst read.
    for (int i = 0; i < 4; i++) wd[i] = 32'hA000_0000 + 32'(i * 32'h0101);
    access(BASE + 32'h10, 1, 4, 4'h0, -1, cyc, lat);
    access(BASE + 32'h10, 0, 4, 4'h0, -1, cyc, lat);
    for (int i = 0; i < 4; i++)
      chk(rd[i] == 32'hA000_0000 + 32'(i * 32'h0101), "R5 burst read word", rd[i], 32'hA000_0000 + 32'(i * 32'h0101));
    chk(cyc == 4 * (NW + 1), "R5 burst cycles", cyc, 4 * (NW + 1));

    // R6: master wait on beat 1 of a burst read.
    access(BASE + 32'h10, 0, 4, 4'h0, 1, cyc, lat);
    chk(cyc == 4 * (NW + 1) + 1, "R6 stalled burst cycles", cyc, 4 * (NW + 1) + 1);
    chk(rd[1] == 32'hA000_0101, "R6 stalled beat data", rd[1], 32'hA000_0101);
    chk(rd[2] == 32'hA000_0202, "R6 beat after stall", rd[2], 32'hA000_0202);

    // R6: master wait on a write beat.
    wd[0] = 32'h5555_0000; wd[1] = 32'h5555_0001;
    access(BASE + 32'h20, 1, 2, 4'h0, 0, cyc, lat);
    access(BASE + 32'h20, 0, 2, 4'h0, -1, cyc, lat);
    chk(rd[0] == 32'h5555_0000 && rd[1] == 32'h5555_0001, "R6 stalled write data", rd[1], 32'h5555_0001);

    // R8: out-of-window writes above and below the window.
    wd[0] = 32'h0BAD_F00D;
    access(BASE + 32'hFC, 1, 1, 4'h0, -1, cyc, lat);
    ignored_write(BASE + WIN * 4, 32'hDEAD_BEEF);
    ignored_write(BASE - 32'h4, 32'hFEED_FACE);
    access(BASE, 0, 1, 4'h0, -1, cyc, lat);
    chk(rd[0] == 32'h11BB_33DD, "R8 first word untouched", rd[0], 32'h11BB_33DD);
    access(BASE + 32'hFC, 0, 1, 4'h0, -1, cyc, lat);
    chk(rd[0] == 32'h0BAD_F00D, "R8 last word untouched", rd[0], 32'h0BAD_F00D);

    repeat (3) @(negedge clk);
    done_flag = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule